// File: doc/BRIEF.md
# GPIO Edge-Detect Interrupt Unit

This block watches a bank of general-purpose input pins (90 by default) and records, per pin, whether a rising or falling transition of an enabled kind has been seen. Each pin has its own rising-edge enable and falling-edge enable. A recorded event is held in a sticky status bit until software clears it by writing a one to that bit.

Three interrupt lines leave the block. Pin 0 and pin 1 each have a private line. Every other pin feeds one shared line, which stays high while any of their status bits is set. Asynchronous pin inputs are first retimed by a synchroniser chain. A small word-addressed register port gives access to the enable and status words.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset all enable bits and all status bits are 0, every register word reads 0 and all three interrupt outputs are low.
- R2: A status bit sets when its pin shows a 0-to-1 transition and its rising enable bit is 1, or a 1-to-0 transition and its falling enable bit is 1. A transition of a kind not enabled for that pin leaves the bit at 0.
- R3: A set status bit stays set through later cycles and through writes that carry 0 in its position.
- R4: Writing a 1 to a status bit position clears that bit. Writing 0 leaves it unchanged.
- R5: If an enabled edge and a write-1 clear reach the same status bit on the same clock edge, the bit ends up set.
- R6: irq_pin0_o equals status bit 0 and irq_pin1_o equals status bit 1.
- R7: irq_shared_o is high exactly while at least one status bit for pins 2 and above is set.
- R8: The map uses word addresses. Words 0..2 hold rising enables, words 3..5 hold falling enables and words 6..8 hold status. Bit k of the third word in each group is pin 32*g+k, where g is its index in the group. Bits 26..31 of words 2, 5 and 8 read 0 and ignore writes, and addresses 9 and above read 0.
- R9: A pin change driven between two clock edges shows up in the status bit just after the third rising clock edge that follows it, and not earlier.
- R10: Enable words are plain read/write storage and read back the value last written, within their implemented bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pins_i | input | NUM_PINS | Asynchronous pin levels |
| reg_valid_i | input | 1 | Register access strobe, one cycle |
| reg_write_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | ADDR_W | Word address |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data, combinational from address |
| irq_pin0_o | output | 1 | Interrupt for pin 0 |
| irq_pin1_o | output | 1 | Interrupt for pin 1 |
| irq_shared_o | output | 1 | Shared interrupt for pins 2 and above |

## Verification
A pin level is driven on a falling clock edge. Its status bit is due after the third rising edge: two edges pass through the synchroniser and one through the edge register into status. The latency check reads the bit after the second edge and expects 0, then after the third and expects 1. Register writes take effect on the single rising edge inside the write task. Reads and interrupt levels are combinational, so they are sampled one time step after the address is driven, half a period away from any edge. The set-against-clear test places the clear write on exactly the third edge after the pin change.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
   // number of DATA_W words needed to hold one bit per pin
   function automatic int words_for(input int pins, input int data_w);
      return (pins + data_w - 1) / data_w;
   endfunction

   // implemented bit count of word w
   function automatic int word_bits(input int pins, input int data_w, input int w);
      int rest;
      rest = pins - w * data_w;
      return (rest < data_w) ? rest : data_w;
   endfunction
endpackage

// File: rtl/gei_sync_edge.sv
module gei_sync_edge #(
   parameter int NUM_PINS    = 90,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pins_i,
   output logic [NUM_PINS-1:0] rise_o,
   output logic [NUM_PINS-1:0] fall_o
);
   logic [NUM_PINS-1:0] stg_q [SYNC_STAGES];
   logic [NUM_PINS-1:0] prev_q;
   logic [NUM_PINS-1:0] cur;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < SYNC_STAGES; i++) stg_q[i] <= '0;
         prev_q <= '0;
      end else begin
         stg_q[0] <= pins_i;
         for (int i = 1; i < SYNC_STAGES; i++) stg_q[i] <= stg_q[i-1];
         prev_q <= stg_q[SYNC_STAGES-1];
      end
   end

   assign cur    = stg_q[SYNC_STAGES-1];
   assign rise_o = cur & ~prev_q;
   assign fall_o = ~cur & prev_q;
endmodule

// File: rtl/gei_regfile.sv
module gei_regfile
   import gpio_edge_pkg::*;
#(
   parameter int NUM_PINS = 90,
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_valid_i,
   input  logic                reg_write_i,
   input  logic [ADDR_W-1:0]   reg_addr_i,
   input  logic [DATA_W-1:0]   reg_wdata_i,
   output logic [DATA_W-1:0]   reg_rdata_o,
   input  logic [NUM_PINS-1:0] status_i,
   output logic [NUM_PINS-1:0] rise_en_o,
   output logic [NUM_PINS-1:0] fall_en_o,
   output logic [NUM_PINS-1:0] clr_o
);
   localparam int NUM_WORDS = words_for(NUM_PINS, DATA_W);
   localparam int PAD_W     = NUM_WORDS * DATA_W;
   localparam int RISE_BASE = 0;
   localparam int FALL_BASE = NUM_WORDS;
   localparam int STAT_BASE = 2 * NUM_WORDS;

   logic              wr_go;
   logic [PAD_W-1:0]  rise_pad, fall_pad, stat_pad;

   assign wr_go = reg_valid_i & reg_write_i;

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      localparam int LO  = w * DATA_W;
      localparam int WID = word_bits(NUM_PINS, DATA_W, w);
      logic hit_rise, hit_fall, hit_stat;

      assign hit_rise = wr_go && (reg_addr_i == ADDR_W'(RISE_BASE + w));
      assign hit_fall = wr_go && (reg_addr_i == ADDR_W'(FALL_BASE + w));
      assign hit_stat = wr_go && (reg_addr_i == ADDR_W'(STAT_BASE + w));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rise_en_o[LO +: WID] <= '0;
            fall_en_o[LO +: WID] <= '0;
         end else begin
            if (hit_rise) rise_en_o[LO +: WID] <= reg_wdata_i[WID-1:0];
            if (hit_fall) fall_en_o[LO +: WID] <= reg_wdata_i[WID-1:0];
         end
      end

      assign clr_o[LO +: WID] = hit_stat ? reg_wdata_i[WID-1:0] : '0;
   end

   assign rise_pad = PAD_W'(rise_en_o);
   assign fall_pad = PAD_W'(fall_en_o);
   assign stat_pad = PAD_W'(status_i);

   always_comb begin
      reg_rdata_o = '0;
      for (int i = 0; i < NUM_WORDS; i++) begin
         if (reg_addr_i == ADDR_W'(RISE_BASE + i)) reg_rdata_o = rise_pad[i*DATA_W +: DATA_W];
         if (reg_addr_i == ADDR_W'(FALL_BASE + i)) reg_rdata_o = fall_pad[i*DATA_W +: DATA_W];
         if (reg_addr_i == ADDR_W'(STAT_BASE + i)) reg_rdata_o = stat_pad[i*DATA_W +: DATA_W];
      end
   end
endmodule

// File: rtl/gei_status.sv
module gei_status #(
   parameter int NUM_PINS = 90
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] rise_i,
   input  logic [NUM_PINS-1:0] fall_i,
   input  logic [NUM_PINS-1:0] rise_en_i,
   input  logic [NUM_PINS-1:0] fall_en_i,
   input  logic [NUM_PINS-1:0] clr_i,
   output logic [NUM_PINS-1:0] status_o
);
   logic [NUM_PINS-1:0] set_vec;

   assign set_vec = (rise_i & rise_en_i) | (fall_i & fall_en_i);

   // set has priority over a same-cycle clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status_o <= '0;
      else        status_o <= (status_o & ~clr_i) | set_vec;
   end

   // R3: bits not cleared stay set
   a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(status_o) & ~$past(clr_i) & ~status_o) == '0));

   // R5: an enabled edge always lands, clear or not
   a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(set_vec) & ~status_o) == '0));

   // R2: no bit rises without a matching enabled edge
   a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((status_o & ~$past(status_o) & ~$past(set_vec)) == '0));
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
   parameter int NUM_PINS    = 90,
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pins_i,
   input  logic                reg_valid_i,
   input  logic                reg_write_i,
   input  logic [ADDR_W-1:0]   reg_addr_i,
   input  logic [DATA_W-1:0]   reg_wdata_i,
   output logic [DATA_W-1:0]   reg_rdata_o,
   output logic                irq_pin0_o,
   output logic                irq_pin1_o,
   output logic                irq_shared_o
);
   localparam int NUM_WORDS = gpio_edge_pkg::words_for(NUM_PINS, DATA_W);

   if (NUM_PINS < 3) begin : g_bad_pins
      $error("NUM_PINS must be at least 3");
   end
   if (3 * NUM_WORDS > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too narrow for the register map");
   end

   logic [NUM_PINS-1:0] rise, fall, rise_en, fall_en, clr, status;

   gei_sync_edge #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pins_i(pins_i), .rise_o(rise), .fall_o(fall)
   );

   gei_regfile #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .reg_valid_i(reg_valid_i), .reg_write_i(reg_write_i),
      .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
      .status_i(status), .rise_en_o(rise_en), .fall_en_o(fall_en), .clr_o(clr)
   );

   gei_status #(.NUM_PINS(NUM_PINS)) u_status (
      .clk(clk), .rst_n(rst_n), .rise_i(rise), .fall_i(fall),
      .rise_en_i(rise_en), .fall_en_i(fall_en), .clr_i(clr), .status_o(status)
   );

   assign irq_pin0_o   = status[0];
   assign irq_pin1_o   = status[1];
   assign irq_shared_o = |status[NUM_PINS-1:2];

   // R6: the pin 0 line only rises after a detected edge on pin 0
   a_r6_pin0_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_pin0_o) |-> $past(rise[0] | fall[0]));

   // R7: the shared line only drops after a register write
   a_r7_shared_drop: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_shared_o) |-> $past(reg_valid_i & reg_write_i));
endmodule

// File: tb/gpio_edge_irq_tb.sv
`timescale 1ns/1ps
module gpio_edge_irq_tb;
   localparam int NP = 90;
   localparam int NV = 11;
   // entry: [10:4] pin, [3] rise enable, [2] fall enable, [1] edge 1=rise, [0] expected status
   localparam logic [10:0] VEC [NV] = '{
      {7'd0,  1'b1, 1'b0, 1'b1, 1'b1},
      {7'd0,  1'b0, 1'b1, 1'b1, 1'b0},
      {7'd1,  1'b0, 1'b1, 1'b0, 1'b1},
      {7'd1,  1'b1, 1'b0, 1'b0, 1'b0},
      {7'd31, 1'b1, 1'b1, 1'b1, 1'b1},
      {7'd32, 1'b1, 1'b1, 1'b0, 1'b1},
      {7'd63, 1'b1, 1'b0, 1'b0, 1'b0},
      {7'd64, 1'b0, 1'b1, 1'b0, 1'b1},
      {7'd89, 1'b1, 1'b0, 1'b1, 1'b1},
      {7'd50, 1'b0, 1'b0, 1'b1, 1'b0},
      {7'd2,  1'b0, 1'b1, 1'b0, 1'b1}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NP-1:0] pins = '0;
   logic          reg_valid = 1'b0, reg_write = 1'b0;
   logic [3:0]    reg_addr = '0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic          irq0, irq1, irqs;
   int            n_checks = 0, n_errors = 0;

   always #2.5 clk = ~clk;

   gpio_edge_irq u_dut (
      .clk(clk), .rst_n(rst_n), .pins_i(pins),
      .reg_valid_i(reg_valid), .reg_write_i(reg_write), .reg_addr_i(reg_addr),
      .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
      .irq_pin0_o(irq0), .irq_pin1_o(irq1), .irq_shared_o(irqs)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_valid = 1'b0; reg_write = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      reg_addr = a; reg_valid = 1'b1; reg_write = 1'b0;
      #1;
      d = reg_rdata;
      reg_valid = 1'b0;
   endtask

   task automatic clear_all();
      for (int a = 0; a < 6; a++) wr(4'(a), 32'h0);
      for (int a = 6; a < 9; a++) wr(4'(a), 32'hFFFF_FFFF);
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      finish_run();
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      for (int a = 0; a < 9; a++) begin
         rd(4'(a), d);
         chk("R1 word reset", d, 32'h0);
      end
      chk("R1 irq reset", {29'h0, irq0, irq1, irqs}, 32'h0);

      // R10 / R8: readback and unused bits
      wr(4'd0, 32'hA5A5_A5A5);
      rd(4'd0, d); chk("R10 rise word readback", d, 32'hA5A5_A5A5);
      wr(4'd4, 32'h1234_5678);
      rd(4'd4, d); chk("R10 fall word readback", d, 32'h1234_5678);
      wr(4'd2, 32'hFFFF_FFFF);
      rd(4'd2, d); chk("R8 top rise word unused bits", d, 32'h03FF_FFFF);
      wr(4'd5, 32'hFFFF_FFFF);
      rd(4'd5, d); chk("R8 top fall word unused bits", d, 32'h03FF_FFFF);
      rd(4'd9, d); chk("R8 unmapped address", d, 32'h0);
      clear_all();

      // R2 / R6 / R7 / R8: vector table
      for (int v = 0; v < NV; v++) begin
         int p, w, b;
         logic e;
         p = int'(VEC[v][10:4]); w = p / 32; b = p % 32; e = VEC[v][0];
         clear_all();
         if (VEC[v][3]) wr(4'(w), 32'h1 << b);
         if (VEC[v][2]) wr(4'(3 + w), 32'h1 << b);
         @(negedge clk); pins[p] = ~VEC[v][1];
         repeat (4) @(negedge clk);
         for (int a = 6; a < 9; a++) wr(4'(a), 32'hFFFF_FFFF);
         pins[p] = VEC[v][1];
         repeat (3) @(posedge clk);
         @(negedge clk);
         rd(4'(6 + w), d);
         chk($sformatf("R2 vector %0d status", v), {31'h0, d[b]}, {31'h0, e});
         if (p == 0)      chk("R6 pin0 line", {31'h0, irq0}, {31'h0, e});
         else if (p == 1) chk("R6 pin1 line", {31'h0, irq1}, {31'h0, e});
         else             chk("R7 shared line", {31'h0, irqs}, {31'h0, e});
      end

      // R9: latency
      clear_all();
      wr(4'd1, 32'h100);
      @(negedge clk); pins[40] = 1'b0;
      repeat (4) @(negedge clk);
      wr(4'd7, 32'hFFFF_FFFF);
      pins[40] = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rd(4'd7, d); chk("R9 not yet after two edges", {31'h0, d[8]}, 32'h0);
      @(negedge clk);
      rd(4'd7, d); chk("R9 set after third edge", {31'h0, d[8]}, 32'h1);

      // R4 / R3
      wr(4'd7, 32'h0);
      rd(4'd7, d); chk("R4 write zero keeps bit", {31'h0, d[8]}, 32'h1);
      wr(4'd7, 32'h8);
      rd(4'd7, d); chk("R3 other-bit clear keeps bit", {31'h0, d[8]}, 32'h1);
      repeat (5) @(negedge clk);
      rd(4'd7, d); chk("R3 holds over idle cycles", {31'h0, d[8]}, 32'h1);
      wr(4'd7, 32'h100);
      rd(4'd7, d); chk("R4 write one clears", {31'h0, d[8]}, 32'h0);
      chk("R7 shared low after clear", {31'h0, irqs}, 32'h0);

      // R5: set wins over simultaneous clear
      pins[40] = 1'b0;
      repeat (4) @(negedge clk);
      wr(4'd7, 32'hFFFF_FFFF);
      pins[40] = 1'b1;
      repeat (2) @(posedge clk);
      wr(4'd7, 32'h100);
      rd(4'd7, d); chk("R5 set beats clear", {31'h0, d[8]}, 32'h1);
      wr(4'd7, 32'h100);

      // R7: two shared sources
      clear_all();
      wr(4'd0, 32'h4);
      wr(4'd2, 32'h0200_0000);
      @(negedge clk); pins[2] = 1'b0; pins[89] = 1'b0;
      repeat (4) @(negedge clk);
      for (int a = 6; a < 9; a++) wr(4'(a), 32'hFFFF_FFFF);
      pins[2] = 1'b1; pins[89] = 1'b1;
      repeat (4) @(negedge clk);
      chk("R7 shared high with two sources", {31'h0, irqs}, 32'h1);
      wr(4'd6, 32'h4);
      chk("R7 shared high with one left", {31'h0, irqs}, 32'h1);
      rd(4'd8, d); chk("R8 pin 89 at word 8 bit 25", d, 32'h0200_0000);
      wr(4'd8, 32'h0200_0000);
      chk("R7 shared low when none left", {31'h0, irqs}, 32'h0);

      finish_run();
   end
endmodule